// File: doc/BRIEF.md
# Per-Thread Loop Stream Buffer

This block sits between the micro-op decoder and the back end of a core that runs two hardware threads. Each thread owns a private replay store. The block watches the decoded micro-ops of that thread for a short loop. A loop shows up as a backward taken branch that goes to the same target twice in a row. On the next pass the block records the loop body. Once the closing branch has been recorded, the thread switches to replay. From then on the body is issued from the store over and over, and the branch predictor is told to stop predicting for that thread.

A single output slot carries at most one micro-op per cycle. The slot comes either from a thread's decoder path or from its replay store. Threads that have work share the slot in round-robin order. A thread with nothing to issue gives up its turn. Branch resolution still arrives from the back end during replay, and a misresolution ends replay at once. A back-end flush or the disabling of a thread clears only that thread. The micro-op payload is carried as an opaque field.

Top module: `loop_stream_buf`

## Requirements
- R1: After reset, `out_valid` and both `stop_pred` bits are 0. Each thread starts in the idle state with an empty store.
- R2: Outside replay, a micro-op accepted from a thread (`dec_valid` and `dec_ready` both 1 at a clock edge) appears on `out_valid`/`out_tid`/`out_payload` after that edge. It carries its own payload, and `out_tid` equals the thread index (0 or 1).
- R3: A micro-op with `dec_back_br`=1 is a backward taken branch, and `dec_target` is its target. Two such branches in a row with equal targets arm capture. The next pass is recorded, up to and including the closing branch with that target. Replay starts on the cycle after the closing branch is accepted, and `stop_pred` for the thread is 1 for as long as replay lasts.
- R4: During replay the thread issues the recorded body in order and wraps back to its first entry without end. Its `dec_ready` is 0 the whole time.
- R5: A body of DEPTH entries or fewer (closing branch included) goes to replay. If the DEPTH+1-th micro-op of a capture is accepted, the capture is dropped and the thread returns to idle without replaying.
- R6: A misresolution (`br_misres`) during replay takes the thread out of replay on the next edge. The thread spends one flush cycle with nothing issued and then takes decoder micro-ops again. A misresolution outside replay has no effect.
- R7: A pulse on `be_flush` or a low `thr_enable` clears that thread's state and store. The other thread keeps running undisturbed.
- R8: When both threads request the slot, grants alternate between them every cycle. A lone requester gets every cycle.
- R9: Store capacity is DEPTH per thread in all cases. A body of exactly DEPTH entries is captured and replayed while the other thread is also active.
- R10: While waiting for the second branch, a backward branch to a different target restarts detection with the new target, and nothing is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_enable | input | 2 | Per-thread enable; low clears that thread |
| dec_valid | input | 2 | Decoder has a micro-op for the thread |
| dec_payload | input | 2 x PW | Opaque micro-op payload per thread |
| dec_back_br | input | 2 | Micro-op is a backward taken branch |
| dec_target | input | 2 x TW | Target of that branch |
| dec_ready | output | 2 | Micro-op accepted this cycle |
| be_flush | input | 2 | Back-end flush per thread |
| br_misres | input | 2 | Branch misresolution per thread |
| stop_pred | output | 2 | Predictor stop for a thread in replay |
| out_valid | output | 1 | Output slot holds a micro-op |
| out_tid | output | 1 | Thread of the issued micro-op |
| out_payload | output | PW | Issued payload |

## Verification
The bench runs with a store of 8 entries and sweeps body lengths from 1 to 9. This covers the single-branch loop, the exactly-full store and the one-over abort. An off-by-one in the fill test would either replay a 9-entry loop with a dropped or wrapped entry, or refuse a full 8-entry loop. The replay stream is compared entry by entry against the body, so a read pointer that misses its wrap or restarts late shows up as a wrong payload. Further checks cover a switched branch target, which a loose detector would capture too early, and a misresolution outside replay, which a careless design would treat as a flush. Flush and disable are applied to one thread while the other is replaying, and the grant sequence is checked for strict alternation, which exposes a crossed clear or a fixed-priority arbiter.

// File: rtl/lsb_pkg.sv
package lsb_pkg;
  localparam int unsigned NUM_THR = 2;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_DETECT  = 3'd1,
    ST_CAPTURE = 3'd2,
    ST_STREAM  = 3'd3,
    ST_FLUSH   = 3'd4
  } lsb_state_e;

  // Replay pointer advance with wrap at the recorded body length.
  function automatic int unsigned ring_next(int unsigned ptr, int unsigned len);
    return (ptr + 1 >= len) ? 0 : ptr + 1;
  endfunction

  // True while the store still has a free entry for the next capture write.
  function automatic logic has_room(int unsigned fill, int unsigned depth);
    return fill < depth;
  endfunction
endpackage

// File: rtl/lsb_rr_arb.sv
module lsb_rr_arb (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] req,
  output logic [1:0] grant
);
  logic last_q;   // thread granted most recently

  always_comb begin
    if (req == 2'b11) grant = last_q ? 2'b01 : 2'b10;
    else              grant = req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          last_q <= 1'b1;
    else if (|grant)     last_q <= grant[1];
  end
endmodule

// File: rtl/lsb_thread.sv
module lsb_thread
  import lsb_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int PW    = 32,
  parameter int TW    = 16,
  localparam int IW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          flush_req,
  input  logic          misres,
  input  logic          in_valid,
  input  logic [PW-1:0] in_payload,
  input  logic          in_back_br,
  input  logic [TW-1:0] in_tgt,
  input  logic          grant,
  output logic          req,
  output logic          accept,
  output logic [PW-1:0] slot_payload,
  output logic          streaming,
  output logic [CW-1:0] fill
);
  lsb_state_e    state_q;
  logic [TW-1:0] tgt_q;
  logic [CW-1:0] wptr_q, len_q;
  logic [IW-1:0] rptr_q;
  logic [PW-1:0] mem_q [DEPTH];

  logic kill, emit, same_tgt, room, wr_en;

  assign streaming    = (state_q == ST_STREAM);
  assign kill         = !enable || flush_req || (streaming && misres);
  assign req          = !kill && (streaming || (state_q != ST_FLUSH && in_valid));
  assign accept       = grant && !streaming;
  assign emit         = grant && streaming;
  assign same_tgt     = in_back_br && (in_tgt == tgt_q);
  assign room         = has_room(32'(wptr_q), DEPTH);
  assign wr_en        = (state_q == ST_CAPTURE) && accept && room;
  assign slot_payload = streaming ? mem_q[rptr_q] : in_payload;
  assign fill         = wptr_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wptr_q[IW-1:0]] <= in_payload;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tgt_q   <= '0;
      wptr_q  <= '0;
      len_q   <= '0;
      rptr_q  <= '0;
    end else if (kill) begin
      state_q <= ST_FLUSH;
      wptr_q  <= '0;
      len_q   <= '0;
      rptr_q  <= '0;
    end else begin
      case (state_q)
        ST_FLUSH: begin
          state_q <= ST_IDLE;
          wptr_q  <= '0;
          len_q   <= '0;
          rptr_q  <= '0;
        end
        ST_IDLE: if (accept && in_back_br) begin
          tgt_q   <= in_tgt;
          state_q <= ST_DETECT;
        end
        ST_DETECT: if (accept && in_back_br) begin
          if (same_tgt) begin
            state_q <= ST_CAPTURE;
            wptr_q  <= '0;
          end else begin
            tgt_q <= in_tgt;
          end
        end
        ST_CAPTURE: if (accept) begin
          if (!room) begin
            state_q <= ST_IDLE;
            wptr_q  <= '0;
          end else if (same_tgt) begin
            state_q <= ST_STREAM;
            len_q   <= wptr_q + 1'b1;
            rptr_q  <= '0;
          end else if (in_back_br) begin
            state_q <= ST_DETECT;
            tgt_q   <= in_tgt;
            wptr_q  <= '0;
          end else begin
            wptr_q <= wptr_q + 1'b1;
          end
        end
        ST_STREAM: if (emit) begin
          rptr_q <= IW'(ring_next(32'(rptr_q), 32'(len_q)));
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/loop_stream_buf.sv
module loop_stream_buf
  import lsb_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int PW    = 32,
  parameter int TW    = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            thr_enable,
  input  logic [1:0]            dec_valid,
  input  logic [1:0][PW-1:0]    dec_payload,
  input  logic [1:0]            dec_back_br,
  input  logic [1:0][TW-1:0]    dec_target,
  output logic [1:0]            dec_ready,
  input  logic [1:0]            be_flush,
  input  logic [1:0]            br_misres,
  output logic [1:0]            stop_pred,
  output logic                  out_valid,
  output logic                  out_tid,
  output logic [PW-1:0]         out_payload
);
  localparam int CW = $clog2(DEPTH + 1);

  // Named internal events, observed by the bound checker.
  logic [1:0]          thr_req;
  logic [1:0]          thr_grant;
  logic [1:0][CW-1:0]  thr_fill;
  logic [1:0][PW-1:0]  thr_slot;

  for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
    lsb_thread #(.DEPTH(DEPTH), .PW(PW), .TW(TW)) u_thread (
      .clk          (clk),
      .rst_n        (rst_n),
      .enable       (thr_enable[t]),
      .flush_req    (be_flush[t]),
      .misres       (br_misres[t]),
      .in_valid     (dec_valid[t]),
      .in_payload   (dec_payload[t]),
      .in_back_br   (dec_back_br[t]),
      .in_tgt       (dec_target[t]),
      .grant        (thr_grant[t]),
      .req          (thr_req[t]),
      .accept       (dec_ready[t]),
      .slot_payload (thr_slot[t]),
      .streaming    (stop_pred[t]),
      .fill         (thr_fill[t])
    );
  end

  lsb_rr_arb u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (thr_req),
    .grant (thr_grant)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_tid     <= 1'b0;
      out_payload <= '0;
    end else begin
      out_valid   <= |thr_grant;
      out_tid     <= thr_grant[1];
      out_payload <= thr_grant[1] ? thr_slot[1] : thr_slot[0];
    end
  end
endmodule

// File: rtl/lsb_checker.sv
module lsb_checker #(
  parameter int DEPTH = 64,
  parameter int CW    = 7
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [1:0]           thr_enable,
  input logic [1:0]           be_flush,
  input logic [1:0]           br_misres,
  input logic [1:0]           dec_ready,
  input logic [1:0]           stop_pred,
  input logic [1:0]           thr_req,
  input logic [1:0]           thr_grant,
  input logic [1:0][CW-1:0]   thr_fill,
  input logic                 out_valid
);
  assert_single_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(thr_grant));

  assert_rr_alternate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_req == 2'b11 && thr_grant[0]) |=> (thr_req != 2'b11 || thr_grant[1]));

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);

  for (genvar t = 0; t < 2; t++) begin : g_chk
    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      thr_fill[t] <= CW'(DEPTH));

    assert_no_decode_in_replay_R4: assert property (@(posedge clk) disable iff (!rst_n)
      stop_pred[t] |-> !dec_ready[t]);

    assert_replay_after_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stop_pred[t]) |-> $past(dec_ready[t]));

    assert_misres_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_pred[t] && br_misres[t]) |=> !stop_pred[t]);

    assert_flush_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (be_flush[t] || !thr_enable[t]) |=> (!stop_pred[t] && thr_fill[t] == '0));
  end
endmodule

bind loop_stream_buf lsb_checker #(.DEPTH(DEPTH), .CW(CW)) u_lsb_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .thr_enable (thr_enable),
  .be_flush   (be_flush),
  .br_misres  (br_misres),
  .dec_ready  (dec_ready),
  .stop_pred  (stop_pred),
  .thr_req    (thr_req),
  .thr_grant  (thr_grant),
  .thr_fill   (thr_fill),
  .out_valid  (out_valid)
);

// File: tb/loop_stream_buf_bench.sv
`timescale 1ns/1ps
module loop_stream_buf_bench;
  localparam int D  = 8;
  localparam int PW = 16;
  localparam int TW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] en = 2'b11, dv = '0, br = '0, fl = '0, mr = '0;
  logic [1:0][PW-1:0] pay = '0;
  logic [1:0][TW-1:0] tg  = '0;
  logic [1:0] dec_ready, stop_pred;
  logic out_valid, out_tid;
  logic [PW-1:0] out_payload;

  int checks = 0;
  int errors = 0;

  logic [PW-1:0] logs [2][2048];
  int            cnt  [2];
  logic          gseq [4096];
  int            gcnt = 0;

  always #2 clk = ~clk;   // 250 MHz

  loop_stream_buf #(.DEPTH(D), .PW(PW), .TW(TW)) u_loop_stream_buf (
    .clk(clk), .rst_n(rst_n), .thr_enable(en), .dec_valid(dv),
    .dec_payload(pay), .dec_back_br(br), .dec_target(tg), .dec_ready(dec_ready),
    .be_flush(fl), .br_misres(mr), .stop_pred(stop_pred),
    .out_valid(out_valid), .out_tid(out_tid), .out_payload(out_payload)
  );

  // Output monitor: samples one time unit after the rising edge.
  initial begin
    cnt[0] = 0;
    cnt[1] = 0;
    forever begin
      @(posedge clk);
      #1;
      if (out_valid) begin
        logs[out_tid][cnt[out_tid]] = out_payload;
        cnt[out_tid] = cnt[out_tid] + 1;
        gseq[gcnt] = out_tid;
        gcnt = gcnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Present one micro-op at a falling edge and hold it until accepted.
  task automatic feed(input int t, input int p, input bit isbr, input int tgt);
    bit acc;
    dv[t] = 1'b1;
    pay[t] = PW'(p);
    br[t] = isbr;
    tg[t] = TW'(tgt);
    do begin
      #1;
      acc = dec_ready[t];
      @(negedge clk);
    end while (!acc);
    dv[t] = 1'b0;
    br[t] = 1'b0;
  endtask

  task automatic feed_iters(input int t, input int len, input int base,
                            input int tgt, input int n);
    for (int it = 0; it < n; it++)
      for (int i = 0; i < len; i++)
        feed(t, base + i, i == len - 1, tgt);
  endtask

  // Entries logs[t][from..cnt-1] must repeat base..base+len-1 from offset 0.
  task automatic check_ring(input int t, input int from, input int len,
                            input int base, input int min_n, input string rq);
    int bad_k = -1;
    for (int k = 0; from + k < cnt[t]; k++)
      if (bad_k < 0 && logs[t][from + k] != PW'(base + (k % len))) bad_k = k;
    chk(cnt[t] - from >= min_n, rq, "replay entry count", cnt[t] - from, min_n);
    if (bad_k >= 0)
      chk(1'b0, rq, "replay payload", int'(logs[t][from + bad_k]),
          base + (bad_k % len));
    else
      chk(1'b1, rq, "replay payload", 0, 0);
  endtask

  task automatic pulse_flush(input int t);
    fl[t] = 1'b1;
    @(negedge clk);
    fl[t] = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int m0, m1, mg, c;
    bit alt;
    // R1: reset state
    tick(3);
    chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
    chk(stop_pred == 2'b00, "R1", "stop_pred in reset", stop_pred, 0);
    rst_n = 1'b1;
    tick(3);
    chk(out_valid == 1'b0 && cnt[0] + cnt[1] == 0, "R1", "idle output after reset",
        cnt[0] + cnt[1], 0);

    // R2/R3/R4/R5/R6: sweep body length 1..D+1 on thread 0
    for (int len = 1; len <= D + 1; len++) begin
      int base = 16'h1000 + len * 16'h40;
      m0 = cnt[0];
      feed_iters(0, len, base, 16 + len, 3);
      tick(2 * len + 4);
      for (int j = 0; j < 3 * len; j++)
        if (logs[0][m0 + j] != PW'(base + (j % len))) begin
          chk(1'b0, "R2", "decoder path payload", int'(logs[0][m0 + j]),
              base + (j % len));
          break;
        end
      chk(1'b1, "R2", "decoder path order", 0, 0);
      if (len <= D) begin
        chk(stop_pred[0] == 1'b1, (len == D) ? "R5" : "R3", "replay entered",
            stop_pred[0], 1);
        check_ring(0, m0 + 3 * len, len, base, 2 * len, "R4");
        dv[0] = 1'b1;
        #1;
        chk(dec_ready[0] == 1'b0, "R4", "decoder held during replay", dec_ready[0], 0);
        @(negedge clk);
        dv[0] = 1'b0;
        mr[0] = 1'b1;
        @(negedge clk);
        mr[0] = 1'b0;
        chk(stop_pred[0] == 1'b0, "R6", "misresolution exits replay", stop_pred[0], 0);
        c = cnt[0];
        tick(3);
        chk(cnt[0] == c, "R6", "no issue after exit", cnt[0] - c, 0);
        feed(0, 16'h0AAA, 1'b0, 0);
        tick(1);
        chk(logs[0][cnt[0] - 1] == 16'h0AAA, "R6", "decoder path resumes",
            int'(logs[0][cnt[0] - 1]), 16'h0AAA);
      end else begin
        chk(stop_pred[0] == 1'b0, "R5", "over-capacity body not replayed",
            stop_pred[0], 0);
        chk(cnt[0] - m0 == 3 * len, "R5", "all uops via decoder", cnt[0] - m0,
            3 * len);
      end
      pulse_flush(0);
    end

    // R10 and ignored misresolution (R6)
    m0 = cnt[0];
    feed(0, 16'h300, 1'b1, 16'h10);
    feed(0, 16'h301, 1'b1, 16'h20);
    mr[0] = 1'b1;
    @(negedge clk);
    mr[0] = 1'b0;
    feed(0, 16'h302, 1'b0, 0);
    feed(0, 16'h303, 1'b1, 16'h20);
    tick(2);
    chk(stop_pred[0] == 1'b0, "R10", "switched target not yet replaying", stop_pred[0], 0);
    feed(0, 16'h304, 1'b0, 0);
    feed(0, 16'h305, 1'b1, 16'h20);
    tick(6);
    chk(stop_pred[0] == 1'b1, "R10", "replay after restarted detection", stop_pred[0], 1);
    chk(stop_pred[0] == 1'b1, "R6", "misresolution outside replay ignored", stop_pred[0], 1);
    check_ring(0, m0 + 6, 2, 16'h304, 4, "R10");
    pulse_flush(0);

    // Two threads: R7, R8, R9
    m0 = cnt[0];
    feed_iters(0, 3, 16'h100, 16'h40, 3);
    m1 = cnt[1];
    feed_iters(1, D, 16'h200, 16'h50, 3);
    tick(2);
    chk(stop_pred == 2'b11, "R9", "full-size body replays with other thread active",
        stop_pred, 3);
    mg = gcnt;
    tick(20);
    alt = 1'b1;
    for (int k = mg + 1; k < gcnt; k++)
      if (gseq[k] == gseq[k - 1]) alt = 1'b0;
    chk(alt && gcnt - mg == 20, "R8", "alternating grants", gcnt - mg, 20);
    check_ring(1, m1 + 3 * D, D, 16'h200, D, "R9");
    pulse_flush(1);
    chk(stop_pred == 2'b01, "R7", "flush clears only its thread", stop_pred, 1);
    c = cnt[0];
    tick(5);
    chk(cnt[0] - c == 5, "R8", "lone requester every cycle", cnt[0] - c, 5);
    check_ring(0, m0 + 9, 3, 16'h100, 10, "R7");
    en[0] = 1'b0;
    @(negedge clk);
    chk(stop_pred[0] == 1'b0, "R7", "disable clears thread", stop_pred[0], 0);
    c = cnt[0];
    tick(2);
    chk(cnt[0] == c, "R7", "disabled thread silent", cnt[0] - c, 0);
    en[0] = 1'b1;
    feed(1, 16'h0BBB, 1'b0, 0);
    tick(1);
    chk(logs[1][cnt[1] - 1] == 16'h0BBB, "R7", "flushed thread takes decoder uops",
        int'(logs[1][cnt[1] - 1]), 16'h0BBB);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule